// File: doc/BRIEF.md
# Octant-Folded Sine/Cosine Generator

This block turns a phase word into a sine sample and a cosine sample. Both are two's complement. Its table covers only the first eighth of a turn and holds both functions for that span. The three most significant phase bits give the octant. The remaining bits give an offset inside the octant. In every second octant that offset is mirrored before it addresses the table. The two table values read out are then exchanged and negated as the octant demands, which rebuilds the whole circle.

The block sits after a phase accumulator and is fully pipelined. When the clock enable is high it accepts one phase word per clock and produces one sample pair per clock. Each result appears a fixed number of enabled clocks after its phase word. When the clock enable is low, the whole pipeline stands still.

Top module: `octant_sincos`

## Requirements
- R1: Reset is synchronous and active low, and it takes effect whether or not the clock enable is high. An edge with `rst_n` low forces `sin_out`, `cos_out` and `out_vld` to zero.
- R2: Let A = 2^(MAG_W-1) and F = 2^(PHASE_W-3). For each table index t in [0, F), the table holds S(t) = floor(A·sin(2πt/2^PHASE_W) + 0.5) and C(t), the same expression with cos. Both are clipped to at most A-1.
- R3: The octant index k is `phase_in[PHASE_W-1:PHASE_W-3]`, and the offset r is the lower PHASE_W-3 bits. When k is odd (1, 3, 5, 7), the table is read at the bitwise complement of r. When k is even, it is read at r.
- R4: In octant 0 the outputs are sin = S(r) and cos = C(r). In octant 1 they are sin = C(~r) and cos = S(~r).
- R5: In octant 2 the outputs are sin = C(r) and cos = -S(r). In octant 3 they are sin = S(~r) and cos = -C(~r).
- R6: In octants 4 to 7, sine is the negation of the octant-0 to octant-3 sine rule. Cosine is, in order: -C(r) for octant 4, -S(~r) for octant 5, +S(r) for octant 6 and +C(~r) for octant 7.
- R7: The positive peak saturates at A-1. Phase 0 gives cos = A-1 and sin = 0. No output ever takes the value -A.
- R8: A phase word that is captured with `ce` high and `phase_vld` high yields `out_vld` high with its sample pair after exactly 7 enabled clock edges, counting the capturing edge. Samples leave in the order their phase words arrived, and a new one can arrive every enabled clock.
- R9: While `ce` is low, the outputs and every pipeline stage hold their values. A phase word presented in such a cycle is not captured, even if `phase_vld` is high.
- R10: A cycle with `ce` high and `phase_vld` low captures no sample. No `out_vld` pulse appears for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes the pipeline |
| phase_in | input | PHASE_W | Phase word; full scale is one turn |
| phase_vld | input | 1 | Marks phase_in as a sample to convert |
| sin_out | output | MAG_W | Sine sample, two's complement |
| cos_out | output | MAG_W | Cosine sample, two's complement |
| out_vld | output | 1 | Marks sin_out and cos_out as a result |

## Verification
A clock-enable stall can arrive in the same cycle as a stream of phase words that cross octant boundaries. When it does, swap and sign information that is still in flight must stay aligned with its table data. The bench drops `ce` at random points while phase words are flowing through every octant, and it keeps `phase_vld` high during some of those stalls. A scoreboard stamps each accepted word with its capturing edge and judges each result on three things: its exact value, its order in the stream, and its latency in enabled edges. While `ce` is low, every output is checked for holding still.

// File: rtl/octant_sincos_pkg.sv
// Shared types for the octant-folded sine/cosine generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package octant_sincos_pkg;

    // Steering decided from the octant index, carried alongside table data
    typedef struct packed {
        logic swap;   // exchange the two table values
        logic neg_s;  // negate the sine result
        logic neg_c;  // negate the cosine result
    } fold_ctrl_t;

endpackage

// File: rtl/octant_fold.sv
// Splits a phase word into a table index and output steering flags.
// Odd octants read the table at the bitwise complement of the in-octant
// offset, which mirrors the phase with a one-LSB shift.
// Assumes: PHASE_W >= 4 so that at least one offset bit exists.
module octant_fold
    import octant_sincos_pkg::*;
#(
    parameter int PHASE_W = 12,
    localparam int OFF_W  = PHASE_W - 3
)(
    input  logic [PHASE_W-1:0] phase,
    output logic [OFF_W-1:0]   tab_idx,
    output fold_ctrl_t         ctrl
);

    logic [2:0]       oct;
    logic [OFF_W-1:0] off;

    assign oct = phase[PHASE_W-1 -: 3];
    assign off = phase[OFF_W-1:0];

    // Mirror the offset in odd octants and derive swap/negate steering
    always_comb begin
        tab_idx    = oct[0] ? ~off : off;
        ctrl.swap  = oct[0] ^ oct[1];
        ctrl.neg_s = oct[2];
        ctrl.neg_c = oct[1] ^ oct[2];
    end

endmodule

// File: rtl/octant_table.sv
// Registered table of sine and cosine over the first eighth of a turn.
// Contents are computed at elaboration with rounding and clipping to A-1.
// Assumes: MAG_W in 10..32, PHASE_W at most 24.
module octant_table #(
    parameter int PHASE_W = 12,
    parameter int MAG_W   = 16,
    localparam int OFF_W  = PHASE_W - 3,
    localparam int DEPTH  = 1 << OFF_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [OFF_W-1:0] idx,
    output logic [MAG_W-1:0] sin_q,
    output logic [MAG_W-1:0] cos_q
);

    localparam real PI    = 3.14159265358979323846;
    localparam real AMP   = 2.0 ** (MAG_W - 1);
    localparam real TOP   = AMP - 1.0;

    logic [MAG_W-1:0] sin_tab [DEPTH];
    logic [MAG_W-1:0] cos_tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam real    ANG  = 2.0 * PI * i / (2.0 ** PHASE_W);
        localparam real    SRAW = $floor(AMP * $sin(ANG) + 0.5);
        localparam real    CRAW = $floor(AMP * $cos(ANG) + 0.5);
        localparam longint SV   = longint'((SRAW > TOP) ? TOP : SRAW);
        localparam longint CV   = longint'((CRAW > TOP) ? TOP : CRAW);
        assign sin_tab[i] = SV[MAG_W-1:0];
        assign cos_tab[i] = CV[MAG_W-1:0];
    end

    // Read both functions at the same index, one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
        end else if (ce) begin
            sin_q <= sin_tab[idx];
            cos_q <= cos_tab[idx];
        end
    end

    // R2: stored values stay inside [0, A-1]
    p_table_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sin_q[MAG_W-1] && !cos_q[MAG_W-1]);

endmodule

// File: rtl/octant_unfold.sv
// Rebuilds full-circle outputs from first-octant values: one stage
// exchanges sine and cosine, the next applies the sign flags.
// Assumes: inputs lie in [0, A-1], so negation never overflows.
module octant_unfold
    import octant_sincos_pkg::*;
#(
    parameter int MAG_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             vld_in,
    input  fold_ctrl_t       ctrl_in,
    input  logic [MAG_W-1:0] s_in,
    input  logic [MAG_W-1:0] c_in,
    output logic             vld_out,
    output logic [MAG_W-1:0] s_out,
    output logic [MAG_W-1:0] c_out
);

    logic             vld_a;
    logic             neg_s_a;
    logic             neg_c_a;
    logic [MAG_W-1:0] s_a;
    logic [MAG_W-1:0] c_a;

    // Stage A: exchange the functions where the octant calls for it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_a   <= 1'b0;
            neg_s_a <= 1'b0;
            neg_c_a <= 1'b0;
            s_a     <= '0;
            c_a     <= '0;
        end else if (ce) begin
            vld_a   <= vld_in;
            neg_s_a <= ctrl_in.neg_s;
            neg_c_a <= ctrl_in.neg_c;
            s_a     <= ctrl_in.swap ? c_in : s_in;
            c_a     <= ctrl_in.swap ? s_in : c_in;
        end
    end

    // Stage B: apply two's complement negation per output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            s_out   <= '0;
            c_out   <= '0;
        end else if (ce) begin
            vld_out <= vld_a;
            s_out   <= neg_s_a ? ('0 - s_a) : s_a;
            c_out   <= neg_c_a ? ('0 - c_a) : c_a;
        end
    end

    // R7: the most negative code never appears on either output
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_out != {1'b1, {(MAG_W-1){1'b0}}}) && (c_out != {1'b1, {(MAG_W-1){1'b0}}}));

endmodule

// File: rtl/octant_sincos.sv
// Top of the octant-folded sine/cosine generator. Registers the phase,
// folds it, reads the eighth-turn table, unfolds, then pads to LATENCY.
// Assumes: LATENCY >= 6, PHASE_W in 4..24, MAG_W in 10..32.
module octant_sincos
    import octant_sincos_pkg::*;
#(
    parameter int PHASE_W = 12,
    parameter int MAG_W   = 16,
    parameter int LATENCY = 7,
    localparam int OFF_W  = PHASE_W - 3,
    localparam int PAD    = LATENCY - 5
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               phase_vld,
    output logic [MAG_W-1:0]   sin_out,
    output logic [MAG_W-1:0]   cos_out,
    output logic               out_vld
);

    logic [PHASE_W-1:0] ph_q;
    logic               v1;
    logic [OFF_W-1:0]   idx_d, idx_q;
    fold_ctrl_t         ctrl_d, ctrl_q, ctrl_t;
    logic               v2, v3;
    logic [MAG_W-1:0]   tab_s, tab_c;
    logic               u_vld;
    logic [MAG_W-1:0]   u_s, u_c;

    // Stage 1: capture the incoming phase word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
            v1   <= 1'b0;
        end else if (ce) begin
            ph_q <= phase_in;
            v1   <= phase_vld;
        end
    end

    octant_fold #(.PHASE_W(PHASE_W)) u_fold (
        .phase   (ph_q),
        .tab_idx (idx_d),
        .ctrl    (ctrl_d)
    );

    // Stage 2: register table index and steering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ctrl_q <= '0;
            v2     <= 1'b0;
        end else if (ce) begin
            idx_q  <= idx_d;
            ctrl_q <= ctrl_d;
            v2     <= v1;
        end
    end

    octant_table #(.PHASE_W(PHASE_W), .MAG_W(MAG_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .idx   (idx_q),
        .sin_q (tab_s),
        .cos_q (tab_c)
    );

    // Stage 3: keep steering aligned with the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_t <= '0;
            v3     <= 1'b0;
        end else if (ce) begin
            ctrl_t <= ctrl_q;
            v3     <= v2;
        end
    end

    octant_unfold #(.MAG_W(MAG_W)) u_unfold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .vld_in  (v3),
        .ctrl_in (ctrl_t),
        .s_in    (tab_s),
        .c_in    (tab_c),
        .vld_out (u_vld),
        .s_out   (u_s),
        .c_out   (u_c)
    );

    logic [PAD-1:0][MAG_W-1:0] pd_s;
    logic [PAD-1:0][MAG_W-1:0] pd_c;
    logic [PAD-1:0]            pd_v;

    // Stages 4+..: delay line that brings the total to LATENCY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_s <= '0;
            pd_c <= '0;
            pd_v <= '0;
        end else if (ce) begin
            pd_s[0] <= u_s;
            pd_c[0] <= u_c;
            pd_v[0] <= u_vld;
            for (int k = 1; k < PAD; k++) begin
                pd_s[k] <= pd_s[k-1];
                pd_c[k] <= pd_c[k-1];
                pd_v[k] <= pd_v[k-1];
            end
        end
    end

    assign sin_out = pd_s[PAD-1];
    assign cos_out = pd_c[PAD-1];
    assign out_vld = pd_v[PAD-1];

    // R9: a low enable freezes every output
    p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(sin_out) && $stable(cos_out) && $stable(out_vld));

    // R1: a reset edge clears the outputs regardless of enable
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !out_vld && (sin_out == '0) && (cos_out == '0));

    // R8: a result can only follow an accepted input at least one edge back
    p_vld_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(ce));

endmodule

// File: tb/octant_sincos_test.sv
module octant_sincos_test;

    localparam int P   = 12;
    localparam int N   = 16;
    localparam int LAT = 7;
    localparam int F   = 1 << (P - 3);
    localparam real PI  = 3.14159265358979323846;
    localparam real AMP = 2.0 ** (N - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce = 1'b0;
    logic [P-1:0] phase_in = '0;
    logic         phase_vld = 1'b0;
    logic [N-1:0] sin_out, cos_out;
    logic         out_vld;

    octant_sincos #(.PHASE_W(P), .MAG_W(N), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .phase_in(phase_in),
        .phase_vld(phase_vld), .sin_out(sin_out), .cos_out(cos_out),
        .out_vld(out_vld)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [P-1:0] ph;
        int           stamp;
        string        tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int en_cnt = 0;
    logic [N-1:0] prev_s = '0, prev_c = '0;
    logic         prev_v = 1'b0;

    // R2 table model from the requirement text
    function automatic longint tab(input int t, input bit is_cos);
        real a, v;
        a = 2.0 * PI * t / (2.0 ** P);
        v = $floor(AMP * (is_cos ? $cos(a) : $sin(a)) + 0.5);
        if (v > AMP - 1.0) v = AMP - 1.0;
        return longint'(v);
    endfunction

    // Expected pair from the per-octant rules R3..R6
    function automatic void model(input logic [P-1:0] ph, output longint es, output longint ec);
        int k, r, m;
        k = int'(ph[P-1 -: 3]);
        r = int'(ph[P-4:0]);
        m = (F - 1) - r;
        case (k)
            0: begin es =  tab(r, 0); ec =  tab(r, 1); end
            1: begin es =  tab(m, 1); ec =  tab(m, 0); end
            2: begin es =  tab(r, 1); ec = -tab(r, 0); end
            3: begin es =  tab(m, 0); ec = -tab(m, 1); end
            4: begin es = -tab(r, 0); ec = -tab(r, 1); end
            5: begin es = -tab(m, 1); ec = -tab(m, 0); end
            6: begin es = -tab(r, 1); ec =  tab(r, 0); end
            default: begin es = -tab(m, 0); ec = tab(m, 1); end
        endcase
    endfunction

    function automatic string tag_for(input logic [P-1:0] ph);
        int k;
        k = int'(ph[P-1 -: 3]);
        if (k < 2) return (k[0]) ? "R3+R4" : "R4";
        if (k < 4) return (k[0]) ? "R3+R5" : "R5";
        return (k[0]) ? "R3+R6" : "R6";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one clock per call, pushes accepted words into the scoreboard
    task automatic drive(input logic [P-1:0] ph, input logic v, input logic e, input string tag);
        @(negedge clk);
        #1;
        phase_in  = ph;
        phase_vld = v;
        ce        = e;
        if (e && v && rst_n) q.push_back('{ph, en_cnt + 1, tag});
    endtask

    // Monitor: compare results, latency and stall behaviour away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ce) begin
                en_cnt++;
                if (out_vld) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R10", "unexpected out_vld", 1, 0);
                    end else begin
                        item_t it;
                        longint es, ec;
                        it = q.pop_front();
                        model(it.ph, es, ec);
                        check(longint'($signed(sin_out)) == es, it.tag, "sine",
                              longint'($signed(sin_out)), es);
                        check(longint'($signed(cos_out)) == ec, it.tag, "cosine",
                              longint'($signed(cos_out)), ec);
                        check(en_cnt - it.stamp == LAT - 1, "R8", "latency edges",
                              en_cnt - it.stamp + 1, LAT);
                    end
                end
            end else begin
                check(sin_out == prev_s && cos_out == prev_c && out_vld == prev_v,
                      "R9", "hold during stall", longint'(out_vld), longint'(prev_v));
            end
        end
        prev_s = sin_out;
        prev_c = cos_out;
        prev_v = out_vld;
    end

    // Watchdog
    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [P-1:0] ph;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_vld == 1'b0 && sin_out == '0 && cos_out == '0, "R1", "reset outputs",
              longint'(out_vld), 0);
        @(negedge clk); #1; rst_n = 1'b1;

        // R7: peak saturation points at phase 0, quarter, half, three quarter
        drive('0, 1, 1, "R7");
        drive(P'(1 << (P - 2)), 1, 1, "R7");
        drive(P'(1 << (P - 1)), 1, 1, "R7");
        drive(P'(3 << (P - 2)), 1, 1, "R7");

        // Octant boundaries: first and last offset in each octant
        for (int k = 0; k < 8; k++) begin
            ph = P'(k * F);
            drive(ph, 1, 1, tag_for(ph));
            ph = P'(k * F + F - 1);
            drive(ph, 1, 1, tag_for(ph));
        end

        // Full sweep with bubbles every 37th cycle (R10)
        for (int i = 0; i < (1 << P); i++) begin
            ph = P'(i);
            drive(ph, (i % 37) != 5, 1, tag_for(ph));
        end

        // Random phases with stalls that still offer valid words (R9)
        for (int i = 0; i < 3000; i++) begin
            ph = P'($urandom);
            if ($urandom_range(0, 4) == 0)
                drive(ph, 1, 0, "R9");
            else
                drive(ph, $urandom_range(0, 7) != 0, 1, tag_for(ph));
        end

        // Drain
        for (int i = 0; i < LAT + 2; i++) drive('0, 0, 1, "R10");
        check(q.size() == 0, "R8", "all samples returned", q.size(), 0);

        // R1: reset wins with ce low mid-stream
        for (int i = 0; i < 4; i++) drive(P'(i * 300), 1, 1, "R4");
        @(negedge clk); #1; ce = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0 && sin_out == '0 && cos_out == '0, "R1",
              "reset with ce low", longint'(out_vld), 0);
        q.delete();
        #1; rst_n = 1'b1; ce = 1'b1; phase_vld = 1'b0;
        for (int i = 0; i < LAT + 2; i++) drive('0, 0, 1, "R10");
        check(q.size() == 0, "R10", "no stray samples after reset", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule